// File: doc/BRIEF.md
# Polling Bus Arbiter

A central controller that settles contention for a shared system bus by polling. Every master adds its pending request onto one shared request line. While that line is high, the controller broadcasts one master address per cycle on a binary poll bus, taken in turn from a small order table. Each master compares the broadcast address with its own fixed identity. The one that is requesting and sees its own address raises the shared busy line and owns the bus. The controller then freezes the poll until busy drops, and continues from the table entry after the winner.

Priority among masters is the content of the order table, not wiring. Software rewrites the table through a write-enable, index and value port, which is honoured only while the controller is idle. A master that does not answer costs one poll cycle and is passed over. The per-master match and ownership logic is part of the block, so the outputs show both the poll bus and which master currently owns the bus.

Top module: `poll_arbiter`

## Requirements
- R1: After a synchronous reset, poll_vld_o, bus_busy_o and grant_o are all 0, poll_addr_o is 0, the read position is entry 0, and entry k of the order table holds master address k.
- R2: While no master requests, poll_vld_o stays 0.
- R3: The cycle after the shared request goes high from idle, poll_vld_o is 1 and poll_addr_o holds the table entry at the read position; each address is shown for exactly one cycle, then the next entry follows, and entry N-1 is followed by entry 0.
- R4: When poll_vld_o is 1 and the master whose identity equals poll_addr_o is requesting, on the next cycle grant_o is one-hot for that master, bus_busy_o is 1, poll_vld_o is 0 and poll_addr_o keeps the winner's address.
- R5: While bus_busy_o is 1, poll_addr_o does not change, poll_vld_o stays 0 and no other master gains ownership, whatever the other requests do.
- R6: The cycle after the owner drops its request, grant_o and bus_busy_o are 0; one cycle later polling resumes at the table entry after the winner's entry if any request is pending, otherwise the controller goes idle with that entry as its read position.
- R7: A polled master that is not requesting is passed over after its one poll cycle, without stalling the scan.
- R8: A table write (cfg_we_i, index cfg_idx_i, address cfg_val_i) is stored only while the controller is idle; a write while polling or while the bus is owned has no effect. The table order decides which of several requesting masters wins first.
- R9: A table write in the same cycle the request rises from idle is stored, but the first poll address shown is the table content from before that write.
- R10: If the request line falls while polling, poll_vld_o is 0 on the next cycle and the next polling round starts at the entry after the last address shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mst_req_i | input | N_MST | Pending request of each master; their OR forms the shared request line |
| cfg_we_i | input | 1 | Order table write enable |
| cfg_idx_i | input | AW | Order table entry to write |
| cfg_val_i | input | AW | Master address to store in that entry |
| poll_addr_o | output | AW | Broadcast poll address |
| poll_vld_o | output | 1 | Poll strobe: poll_addr_o is a live poll this cycle |
| bus_busy_o | output | 1 | Shared busy line, high while some master owns the bus |
| grant_o | output | N_MST | One-hot owner of the bus, all zero when free |

## Verification
Two functions meet in one cycle: a table write and the start of a polling round, both allowed only from the idle state. The bench raises a request in the very cycle it rewrites the entry at the read position, expects the old address as the first poll, then lets the scan wrap back to that entry and expects the new address there. A second meeting point, the owner's release while another master is already waiting, is provoked by keeping requests pending through every hold, and is judged by the address shown one cycle after busy falls.

// File: rtl/poll_arb_pkg.sv
package poll_arb_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_POLL = 2'd1,
    S_HOLD = 2'd2
  } ctrl_state_t;

endpackage

// File: rtl/poll_order_table.sv
module poll_order_table #(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic          wr_ok_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_val_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_val_o
);

  logic [AW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= AW'(i);
    end else if (we_i && wr_ok_i) begin
      mem[wr_idx_i] <= wr_val_i;
    end
  end

  assign rd_val_o = mem[rd_idx_i];

endmodule

// File: rtl/poll_ctrl.sv
module poll_ctrl
  import poll_arb_pkg::*;
#(
  parameter int N_MST = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any_req_i,
  input  logic          claim_i,
  input  logic          busy_i,
  input  logic [AW-1:0] tbl_val_i,
  output logic [AW-1:0] tbl_idx_o,
  output logic          wr_ok_o,
  output logic [AW-1:0] poll_addr_o,
  output logic          poll_vld_o
);

  localparam logic [AW-1:0] LAST = AW'(N_MST - 1);

  ctrl_state_t   st_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_nxt;

  assign ptr_nxt   = (ptr_q == LAST) ? '0 : ptr_q + AW'(1);
  assign tbl_idx_o = (st_q == S_IDLE) ? ptr_q : ptr_nxt;
  assign wr_ok_o   = (st_q == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_IDLE;
      ptr_q       <= '0;
      poll_addr_o <= '0;
      poll_vld_o  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (any_req_i) begin
            st_q        <= S_POLL;
            poll_addr_o <= tbl_val_i;
            poll_vld_o  <= 1'b1;
          end
        end
        S_POLL: begin
          if (claim_i) begin
            st_q       <= S_HOLD;
            poll_vld_o <= 1'b0;
          end else begin
            ptr_q <= ptr_nxt;
            if (any_req_i) begin
              poll_addr_o <= tbl_val_i;
            end else begin
              st_q       <= S_IDLE;
              poll_vld_o <= 1'b0;
            end
          end
        end
        S_HOLD: begin
          if (!busy_i) begin
            ptr_q <= ptr_nxt;
            if (any_req_i) begin
              st_q        <= S_POLL;
              poll_addr_o <= tbl_val_i;
              poll_vld_o  <= 1'b1;
            end else begin
              st_q <= S_IDLE;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R5: poll address frozen and strobe off while the bus is held
  a_r5_frozen_poll: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_HOLD && busy_i) |=> ($stable(poll_addr_o) && !poll_vld_o));

  // R2: no strobe one cycle after an idle cycle with no request
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE && !any_req_i) |=> !poll_vld_o);

endmodule

// File: rtl/poll_agent.sv
module poll_agent #(
  parameter int ID = 0,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] poll_addr_i,
  input  logic          poll_vld_i,
  input  logic          req_i,
  input  logic          busy_i,
  output logic          claim_o,
  output logic          own_o
);

  logic hit;

  assign hit     = poll_vld_i && (poll_addr_i == AW'(ID));
  assign claim_o = hit && req_i && !busy_i;

  always_ff @(posedge clk) begin
    if (rst) own_o <= 1'b0;
    else     own_o <= claim_o || (own_o && req_i);
  end

  // R4: ownership only begins after a live poll of this identity while requesting
  a_r4_own_from_poll: assert property (@(posedge clk) disable iff (rst)
    $rose(own_o) |-> $past(hit && req_i));

  // R6: ownership ends the cycle after the request falls
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    (own_o && !req_i) |=> !own_o);

endmodule

// File: rtl/poll_arbiter.sv
module poll_arbiter #(
  parameter int N_MST = 8,
  parameter int AW    = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_MST-1:0] mst_req_i,
  input  logic             cfg_we_i,
  input  logic [AW-1:0]    cfg_idx_i,
  input  logic [AW-1:0]    cfg_val_i,
  output logic [AW-1:0]    poll_addr_o,
  output logic             poll_vld_o,
  output logic             bus_busy_o,
  output logic [N_MST-1:0] grant_o
);

  logic             any_req;
  logic [N_MST-1:0] claim;
  logic [N_MST-1:0] own;
  logic [AW-1:0]    tbl_idx;
  logic [AW-1:0]    tbl_val;
  logic             wr_ok;

  assign any_req    = |mst_req_i;
  assign bus_busy_o = |own;
  assign grant_o    = own;

  poll_order_table #(.DEPTH(N_MST), .AW(AW)) u_tbl (
    .clk      (clk),
    .rst      (rst),
    .we_i     (cfg_we_i),
    .wr_ok_i  (wr_ok),
    .wr_idx_i (cfg_idx_i),
    .wr_val_i (cfg_val_i),
    .rd_idx_i (tbl_idx),
    .rd_val_o (tbl_val)
  );

  poll_ctrl #(.N_MST(N_MST), .AW(AW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .any_req_i   (any_req),
    .claim_i     (|claim),
    .busy_i      (bus_busy_o),
    .tbl_val_i   (tbl_val),
    .tbl_idx_o   (tbl_idx),
    .wr_ok_o     (wr_ok),
    .poll_addr_o (poll_addr_o),
    .poll_vld_o  (poll_vld_o)
  );

  for (genvar g = 0; g < N_MST; g++) begin : g_agent
    poll_agent #(.ID(g), .AW(AW)) u_agent (
      .clk         (clk),
      .rst         (rst),
      .poll_addr_i (poll_addr_o),
      .poll_vld_i  (poll_vld_o),
      .req_i       (mst_req_i[g]),
      .busy_i      (bus_busy_o),
      .claim_o     (claim[g]),
      .own_o       (own[g])
    );
  end

  // R4: at most one owner at any time
  a_r4_single_owner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  // R5: no live poll while the bus is owned
  a_r5_no_strobe_busy: assert property (@(posedge clk) disable iff (rst)
    bus_busy_o |-> !poll_vld_o);

endmodule

// File: tb/sim_poll_arbiter.sv
module sim_poll_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic          we  = 1'b0;
  logic [AW-1:0] widx = '0;
  logic [AW-1:0] wval = '0;
  logic [AW-1:0] poll_addr;
  logic          poll_vld;
  logic          busy;
  logic [N-1:0]  grant;

  int tests  = 0;
  int failed = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  poll_arbiter #(.N_MST(N)) u0 (
    .clk(clk), .rst(rst), .mst_req_i(req),
    .cfg_we_i(we), .cfg_idx_i(widx), .cfg_val_i(wval),
    .poll_addr_o(poll_addr), .poll_vld_o(poll_vld),
    .bus_busy_o(busy), .grant_o(grant)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic ev, input logic [AW-1:0] ea,
                     input logic [N-1:0] eg);
    tests++;
    if (poll_vld !== ev || busy !== (|eg) || grant !== eg ||
        ((ev || (|eg)) && poll_addr !== ea)) begin
      failed++;
      $display("FAIL %s: vld=%0b addr=%0d grant=%b busy=%0b, expected vld=%0b addr=%0d grant=%b busy=%0b",
               tag, poll_vld, poll_addr, grant, busy, ev, ea, eg, |eg);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", 1'b0, 3'd0, 8'h00);
    tests++;
    if (poll_addr !== 3'd0) begin
      failed++;
      $display("FAIL R1 reset address: addr=%0d expected 0", poll_addr);
    end
  endtask

  task automatic t_idle();
    repeat (3) step();
    chk("R2 idle without request", 1'b0, 3'd0, 8'h00);
  endtask

  task automatic t_scan();
    req[3] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      chk(k < 3 ? "R7 non-requesting master passed" : "R3 identity scan",
          1'b1, AW'(k), 8'h00);
    end
    step();
    chk("R4 master 3 wins", 1'b0, 3'd3, 8'h08);
    req[1] = 1'b1;
    repeat (3) begin
      step();
      chk("R5 hold frozen with rival", 1'b0, 3'd3, 8'h08);
    end
    req[3] = 1'b0;
    step();
    chk("R6 busy falls after release", 1'b0, 3'd3, 8'h00);
    for (int k = 0; k < 6; k++) begin
      step();
      chk("R3 resume and wrap", 1'b1, AW'((4 + k) % N), 8'h00);
    end
    step();
    chk("R4 master 1 wins after wrap", 1'b0, 3'd1, 8'h02);
    req[1] = 1'b0;
    step();
    chk("R6 release", 1'b0, 3'd1, 8'h00);
    step();
    chk("R6 idle when nothing pending", 1'b0, 3'd1, 8'h00);
  endtask

  task automatic t_drop();
    req[6] = 1'b1;
    step();
    chk("R10 start at entry 2", 1'b1, 3'd2, 8'h00);
    step();
    chk("R10 entry 3", 1'b1, 3'd3, 8'h00);
    req[6] = 1'b0;
    step();
    chk("R10 request withdrawn", 1'b0, 3'd3, 8'h00);
    req[6] = 1'b1;
    step();
    chk("R10 resume after last shown", 1'b1, 3'd4, 8'h00);
    step();
    chk("R10 entry 5", 1'b1, 3'd5, 8'h00);
    step();
    chk("R10 entry 6", 1'b1, 3'd6, 8'h00);
    step();
    chk("R4 master 6 wins", 1'b0, 3'd6, 8'h40);
    req[6] = 1'b0;
    step();
    step();
    chk("R6 idle again", 1'b0, 3'd6, 8'h00);
  endtask

  task automatic t_prog();
    logic [AW-1:0] exp_seq [5];
    for (int k = 0; k < N; k++) begin
      we   = 1'b1;
      widx = AW'(k);
      wval = AW'((3 * k + 5) % N);
      step();
    end
    we = 1'b0;
    chk("R8 writes while idle", 1'b0, 3'd0, 8'h00);
    exp_seq = '{3'd2, 3'd5, 3'd0, 3'd3, 3'd6};
    req[4] = 1'b1;
    req[6] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R8 programmed order", 1'b1, exp_seq[k], 8'h00);
    end
    step();
    chk("R8 order gives 6 priority over 4", 1'b0, 3'd6, 8'h40);
    we   = 1'b1;
    widx = 3'd6;
    wval = 3'd0;
    step();
    we = 1'b0;
    chk("R8 write during hold", 1'b0, 3'd6, 8'h40);
    req[6] = 1'b0;
    step();
    chk("R6 release of 6", 1'b0, 3'd6, 8'h00);
    step();
    chk("R6 resume after winner", 1'b1, 3'd1, 8'h00);
    step();
    chk("R8 entry 5", 1'b1, 3'd4, 8'h00);
    step();
    chk("R4 master 4 wins", 1'b0, 3'd4, 8'h10);
    req[4] = 1'b0;
    req[7] = 1'b1;
    step();
    chk("R6 release of 4", 1'b0, 3'd4, 8'h00);
    step();
    chk("R8 write in hold was ignored", 1'b1, 3'd7, 8'h00);
    step();
    chk("R4 master 7 wins", 1'b0, 3'd7, 8'h80);
    req[7] = 1'b0;
    step();
    step();
    chk("R6 idle after 7", 1'b0, 3'd7, 8'h00);
  endtask

  task automatic t_same();
    we     = 1'b1;
    widx   = 3'd7;
    wval   = 3'd5;
    req[5] = 1'b1;
    step();
    we = 1'b0;
    chk("R9 first poll uses old entry", 1'b1, 3'd2, 8'h00);
    step();
    chk("R3 wrap to entry 0", 1'b1, 3'd5, 8'h00);
    step();
    chk("R4 master 5 wins", 1'b0, 3'd5, 8'h20);
    req[5] = 1'b0;
    step();
    step();
    chk("R6 idle after 5", 1'b0, 3'd5, 8'h00);
    req[5] = 1'b1;
    repeat (6) step();
    chk("R7 entries 1-6 passed, entry 6", 1'b1, 3'd7, 8'h00);
    step();
    chk("R9 same-cycle write stored", 1'b1, 3'd5, 8'h00);
    step();
    chk("R4 master 5 wins at entry 7", 1'b0, 3'd5, 8'h20);
    req[5] = 1'b0;
    step();
    step();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    t_reset();
    t_idle();
    t_scan();
    t_drop();
    t_prog();
    t_same();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

endmodule